// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block is a bus master sequencer. It moves one operand of one to four bytes between a requester and an external 32-bit data bus. The target port on that bus may be 8, 16 or 32 bits wide. The controller does not know the port width in advance. Each bus cycle it presents an address, a two-bit code for the bytes still left to move, and a direction. It then waits for the port to answer with a two-bit width acknowledge. The bytes accepted in that cycle follow from the port width, the low address bits and the bytes left. The controller advances the address by that amount and repeats until the operand is complete. A misaligned long word to a byte port therefore takes four cycles, while the same access to a 32-bit port at an aligned address takes one.

The requester raises `req_valid` for one cycle with the direction, the start address, the operand size and the write operand. It then waits for `done`. On a read, `rd_data` holds the assembled operand in the `done` cycle. If a port stays silent for longer than the programmed limit, the transfer stops and `bus_err` is raised together with `done`.

Top module: `dynsz_bus_master`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done`, `bus_as` and `bus_ds` are all low.
- R2: In every bus cycle, `bus_siz` gives the bytes still to move: 01 for one, 10 for two, 11 for three, 00 for four. `req_siz` uses the same code for the operand size.
- R3: `bus_dsack` codes the port width: 00 means no answer yet, 01 an 8-bit port, 10 a 16-bit port, 11 a 32-bit port. The bytes accepted in one cycle are the smaller of the bytes left and the port width in bytes minus (address modulo port width in bytes). The transfer ends once no bytes are left.
- R4: The first bus cycle uses `req_addr`. Each later cycle uses the previous address plus the bytes accepted in the previous cycle, so the number of bus cycles follows from R3.
- R5: A write operand is right-justified in `req_wdata` and its most significant byte is sent first. Lane 0 is `bus_dout[31:24]` and lane 3 is `bus_dout[7:0]`. Let c be the first unsent byte and a the address modulo 4. The lanes then carry these operand bytes: for a=0, c, c+1, c+2, c+3; for a=1, c, c, c+1, c+2; for a=2, c, c+1, c, c+1; for a=3, c on all four lanes. An index past the last operand byte is replaced by the last byte.
- R6: On a read, the port returns byte (a+m) on lane: 0 for an 8-bit port, (a mod 2)+m for a 16-bit port, (a mod 4)+m for a 32-bit port. `rd_data` holds the operand right-justified, first byte most significant, upper unused bytes zero, in the `done` cycle.
- R7: Each bus cycle has three parts: one cycle with `bus_as` high and `bus_ds` low; then both high until an acknowledge is sampled; then one cycle with both low. Address, size code and `bus_rd` stay steady while the strobes are high. `done` comes in the last of these closing cycles, so a transfer of c cycles with w wait cycles each shows `done` c*(w+3) cycles after the request.
- R8: An acknowledge that comes within `timeout_lim` wait cycles is accepted. If `bus_ds` has been high for `timeout_lim`+1 cycles with no acknowledge, the strobes drop and `done` comes with `bus_err` high, `timeout_lim`+3 cycles after the request for a first-cycle timeout.
- R9: A request raised while `busy` is high is ignored and starts no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a transfer (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the first operand byte |
| req_siz | input | 2 | Operand size, coded as in R2 |
| req_wdata | input | 32 | Write operand, right-justified |
| timeout_lim | input | TO_W | Wait cycles allowed before a bus error |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| bus_err | output | 1 | With `done`: transfer ended by timeout |
| rd_data | output | 32 | Assembled read operand |
| bus_addr | output | ADDR_W | Bus address |
| bus_siz | output | 2 | Bytes still to move |
| bus_rd | output | 1 | 1 = read cycle |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_dsack | input | 2 | Port-width acknowledge |

## Verification
The bench targets the cases where the bytes accepted per cycle are set by the address, not by the port. Examples are odd starts on a 16-bit port, a three-byte operand that crosses a word boundary on a 32-bit port, and a long word that needs four cycles on a byte port. A design that got the accepted count or the address step wrong would write bytes to the wrong memory locations, or run too few or too many bus cycles. A write lane that ignores the offset rules would give a byte port or an odd-addressed half-word port a neighbour's byte. A read assembler that picks the wrong start lane would return junk bytes in `rd_data`. The timeout is tested right at its limit and one cycle past it, and a request is raised in the middle of a busy transfer to confirm it is dropped.

// File: rtl/dynsz_pkg.sv
package dynsz_pkg;

  localparam int unsigned LANES = 4;
  localparam int unsigned REM_W = 3;

  localparam logic [1:0] ACK_NONE = 2'b00;
  localparam logic [1:0] ACK_P8   = 2'b01;
  localparam logic [1:0] ACK_P16  = 2'b10;
  localparam logic [1:0] ACK_P32  = 2'b11;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_TERM = 2'd3
  } phase_t;

  // bytes a port of the acknowledged width accepts at this offset
  function automatic logic [REM_W-1:0] bytes_taken(input logic [1:0] ack,
                                                   input logic [1:0] off,
                                                   input logic [REM_W-1:0] rem);
    logic [REM_W-1:0] room;
    case (ack)
      ACK_P8:  room = 3'd1;
      ACK_P16: room = off[0] ? 3'd1 : 3'd2;
      default: room = 3'd4 - {1'b0, off};
    endcase
    return (rem < room) ? rem : room;
  endfunction

  // which remaining operand byte a write lane carries
  function automatic logic [1:0] lane_pick(input int lane,
                                           input logic [1:0] off,
                                           input logic [REM_W-1:0] rem);
    logic [REM_W-1:0] raw;
    logic [REM_W-1:0] last;
    case (lane)
      0:       raw = 3'd0;
      1:       raw = off[0] ? 3'd0 : 3'd1;
      2:       raw = off[1] ? 3'd0 : (3'd2 - {2'b00, off[0]});
      default: raw = 3'd3 - {1'b0, off};
    endcase
    last = rem - 3'd1;
    if (rem != 3'd0 && raw > last) raw = last;
    return raw[1:0];
  endfunction

  // size code: bytes left modulo four
  function automatic logic [1:0] size_code(input logic [REM_W-1:0] rem);
    return rem[1:0];
  endfunction

endpackage

// File: rtl/dynsz_wr_lanes.sv
module dynsz_wr_lanes
  import dynsz_pkg::*;
#(
  parameter int unsigned NL = LANES
) (
  input  logic [8*NL-1:0]  opnd_i,
  input  logic [1:0]       off_i,
  input  logic [REM_W-1:0] rem_i,
  output logic [8*NL-1:0]  lanes_o
);

  logic [7:0] obyte [NL];

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [1:0] src;
    assign obyte[g] = opnd_i[8*(NL-1-g) +: 8];
    assign src      = lane_pick(g, off_i, rem_i);
    assign lanes_o[8*(NL-1-g) +: 8] = obyte[src];
  end

endmodule

// File: rtl/dynsz_rd_merge.sv
module dynsz_rd_merge
  import dynsz_pkg::*;
#(
  parameter int unsigned NL = LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             capture_i,
  input  logic [1:0]       ack_i,
  input  logic [1:0]       off_i,
  input  logic [REM_W-1:0] take_i,
  input  logic [8*NL-1:0]  din_i,
  output logic [8*NL-1:0]  acc_o
);

  localparam int unsigned DW = 8 * NL;

  logic [1:0]    first;
  logic [DW-1:0] grab;
  logic [DW-1:0] acc_q;

  always_comb begin
    case (ack_i)
      ACK_P8:  first = 2'd0;
      ACK_P16: first = {1'b0, off_i[0]};
      default: first = off_i;
    endcase
    grab = '0;
    for (int m = 0; m < NL; m++) begin
      if (3'(m) < take_i) begin
        grab = {grab[DW-9:0], din_i[8*(NL-1-int'(first + 2'(m))) +: 8]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) acc_q <= '0;
    else if (capture_i)    acc_q <= (acc_q << {take_i, 3'b000}) | grab;
  end

  assign acc_o = acc_q;

  assert_capture_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |-> take_i != '0);

endmodule

// File: rtl/dynsz_timeout.sv
module dynsz_timeout #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          ack_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i || ack_i) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && !ack_i && (cnt_q == limit_i);

  assert_expiry_ends_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |=> !run_i);

endmodule

// File: rtl/dynsz_bus_master.sv
module dynsz_bus_master
  import dynsz_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_siz,
  input  logic [31:0]       req_wdata,
  input  logic [TO_W-1:0]   timeout_lim,
  output logic              busy,
  output logic              done,
  output logic              bus_err,
  output logic [31:0]       rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic              bus_rd,
  output logic              bus_as,
  output logic              bus_ds,
  output logic [31:0]       bus_dout,
  input  logic [31:0]       bus_din,
  input  logic [1:0]        bus_dsack
);

  localparam int unsigned DW = 8 * LANES;

  phase_t            phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REM_W-1:0]  rem_q;
  logic [DW-1:0]     sreg_q;
  logic              wr_q;
  logic              err_q;

  logic              start_evt;
  logic              ack_evt;
  logic              expire_evt;
  logic              last_evt;
  logic [REM_W-1:0]  take_w;
  logic [REM_W-1:0]  rem_init;
  logic [DW-1:0]     lanes_w;
  logic [DW-1:0]     acc_w;

  assign start_evt = (phase_q == PH_IDLE) && req_valid;
  assign ack_evt   = (phase_q == PH_STRB) && (bus_dsack != ACK_NONE);
  assign take_w    = bytes_taken(bus_dsack, addr_q[1:0], rem_q);
  assign rem_init  = {req_siz == 2'b00, req_siz};
  assign last_evt  = (phase_q == PH_TERM) && (err_q || rem_q == '0);

  dynsz_timeout #(.CW(TO_W)) u_timeout (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (phase_q == PH_STRB),
    .ack_i     (bus_dsack != ACK_NONE),
    .limit_i   (timeout_lim),
    .expired_o (expire_evt)
  );

  dynsz_wr_lanes #(.NL(LANES)) u_wr_lanes (
    .opnd_i  (sreg_q),
    .off_i   (addr_q[1:0]),
    .rem_i   (rem_q),
    .lanes_o (lanes_w)
  );

  dynsz_rd_merge #(.NL(LANES)) u_rd_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_evt),
    .capture_i (ack_evt && !wr_q),
    .ack_i     (bus_dsack),
    .off_i     (addr_q[1:0]),
    .take_i    (take_w),
    .din_i     (bus_din),
    .acc_o     (acc_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      sreg_q  <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_evt) begin
          phase_q <= PH_ADDR;
          addr_q  <= req_addr;
          rem_q   <= rem_init;
          sreg_q  <= req_wdata << {3'd4 - rem_init, 3'b000};
          wr_q    <= req_write;
          err_q   <= 1'b0;
        end
        PH_ADDR: phase_q <= PH_STRB;
        PH_STRB: begin
          if (ack_evt) begin
            phase_q <= PH_TERM;
            addr_q  <= addr_q + ADDR_W'(take_w);
            rem_q   <= rem_q - take_w;
            sreg_q  <= sreg_q << {take_w, 3'b000};
          end else if (expire_evt) begin
            phase_q <= PH_TERM;
            err_q   <= 1'b1;
          end
        end
        default: phase_q <= last_evt ? PH_IDLE : PH_ADDR;
      endcase
    end
  end

  assign busy     = (phase_q != PH_IDLE);
  assign done     = last_evt;
  assign bus_err  = last_evt && err_q;
  assign rd_data  = acc_w;
  assign bus_addr = addr_q;
  assign bus_siz  = size_code(rem_q);
  assign bus_rd   = !wr_q;
  assign bus_as   = (phase_q == PH_ADDR) || (phase_q == PH_STRB);
  assign bus_ds   = (phase_q == PH_STRB);
  assign bus_dout = wr_q ? lanes_w : '0;

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ds && !ack_evt) |=> ($stable(bus_addr) && $stable(bus_siz) && $stable(bus_rd)));

  assert_addr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> bus_addr == $past(bus_addr) + ADDR_W'($past(take_w)));

  assert_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> rem_q < $past(rem_q));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_as && !bus_ds));

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && !done) |=> busy);

endmodule

// File: tb/dynsz_bus_master_test.sv
module dynsz_bus_master_test;

  localparam int TO_LIM = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_siz = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  timeout_lim = 8'(TO_LIM);
  logic        busy, done, bus_err, bus_rd, bus_as, bus_ds;
  logic [31:0] rd_data, bus_addr, bus_dout;
  logic [31:0] bus_din = '0;
  logic [1:0]  bus_siz;
  logic [1:0]  bus_dsack = 2'b00;

  always #2 clk = ~clk;

  dynsz_bus_master uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_siz(req_siz), .req_wdata(req_wdata),
    .timeout_lim(timeout_lim), .busy(busy), .done(done), .bus_err(bus_err),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_rd(bus_rd),
    .bus_as(bus_as), .bus_ds(bus_ds), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_dsack(bus_dsack)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // fields: wr, addr[3:0], bytes, ack code, wait, spare, data
  localparam logic [47:0] VEC [12] = '{
    {1'b1, 4'h0, 3'd4, 2'b01, 3'd0, 3'd0, 32'h11223344},
    {1'b1, 4'h1, 3'd4, 2'b10, 3'd1, 3'd0, 32'h55667788},
    {1'b1, 4'h2, 3'd4, 2'b11, 3'd0, 3'd0, 32'h99AABBCC},
    {1'b1, 4'h3, 3'd3, 2'b11, 3'd2, 3'd0, 32'h00DDEEF1},
    {1'b1, 4'h0, 3'd2, 2'b10, 3'd0, 3'd0, 32'h00001234},
    {1'b1, 4'h1, 3'd1, 2'b11, 3'd0, 3'd0, 32'h0000005A},
    {1'b0, 4'h0, 3'd4, 2'b11, 3'd0, 3'd0, 32'h0},
    {1'b0, 4'h1, 3'd4, 2'b01, 3'd1, 3'd0, 32'h0},
    {1'b0, 4'h3, 3'd2, 2'b10, 3'd0, 3'd0, 32'h0},
    {1'b0, 4'h2, 3'd3, 2'b11, 3'd3, 3'd0, 32'h0},
    {1'b0, 4'h1, 3'd2, 2'b10, 3'd0, 3'd0, 32'h0},
    {1'b1, 4'h5, 3'd4, 2'b11, 3'd3, 3'd0, 32'hC0FFEE42}
  };

  // port model state
  logic [7:0]  mem [16];
  logic [7:0]  ob [4];
  logic [1:0]  port_ack = 2'b11;
  int          port_wait = 0;
  bit          port_mute = 0;
  int          wcnt = 0;
  bit          acked = 0;
  int          acks = 0;
  logic [31:0] exp_addr = '0;
  int          exp_rem = 0;
  int          opn = 0;
  bit          cur_wr = 0;

  function automatic int lane_tbl(input int a, input int lane);
    case (a)
      0: return lane;
      1: return (lane == 0) ? 0 : lane - 1;
      2: return lane % 2;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    int pb, off, t, k, idx;
    logic [31:0] e, d;
    if (!bus_ds) begin
      bus_dsack = 2'b00;
      acked = 0;
      wcnt = 0;
    end else if (!acked) begin
      if (!port_mute && wcnt == port_wait) begin
        pb  = (port_ack == 2'b01) ? 1 : (port_ack == 2'b10) ? 2 : 4;
        off = int'(exp_addr[1:0]) % pb;
        t   = pb - off;
        if (t > exp_rem) t = exp_rem;
        k   = opn - exp_rem;
        chk(bus_siz == 2'(exp_rem), "R2 size code", {30'd0, bus_siz}, 32'(exp_rem % 4));
        chk(bus_addr == exp_addr, "R4 cycle address", bus_addr, exp_addr);
        chk(bus_rd == !cur_wr, "R7 direction", {31'd0, bus_rd}, {31'd0, !cur_wr});
        if (cur_wr) begin
          e = '0;
          for (int ln = 0; ln < 4; ln++) begin
            idx = lane_tbl(int'(exp_addr[1:0]), ln);
            if (idx > exp_rem - 1) idx = exp_rem - 1;
            e[8*(3-ln) +: 8] = ob[k + idx];
          end
          chk(bus_dout == e, "R5 write lanes", bus_dout, e);
          for (int m = 0; m < t; m++) mem[4'(exp_addr + 32'(m))] = bus_dout[8*(3-(off+m)) +: 8];
        end else begin
          d = 32'hEEEEEEEE;
          for (int m = 0; m < t; m++) d[8*(3-(off+m)) +: 8] = mem[4'(exp_addr + 32'(m))];
          bus_din = d;
        end
        exp_addr = exp_addr + 32'(t);
        exp_rem  = exp_rem - t;
        acks++;
        acked = 1;
        bus_dsack = port_ack;
      end else begin
        wcnt++;
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic run_xfer(input bit wr, input logic [31:0] addr, input int n,
                          input logic [31:0] data, input logic [1:0] ack, input int w,
                          input bit mute, input int inject_at, output int cnt);
    for (int i = 0; i < 16; i++) mem[i] = 8'hA0 + 8'(i);
    for (int j = 0; j < n; j++) ob[j] = data[8*(n-1-j) +: 8];
    exp_addr = addr; exp_rem = n; opn = n; cur_wr = wr;
    port_ack = ack; port_wait = w; port_mute = mute; acks = 0;
    @(negedge clk);
    req_write = wr; req_addr = addr; req_siz = 2'(n); req_wdata = data; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 1;
    while (!done && cnt < 200) begin
      @(negedge clk);
      cnt++;
      if (cnt == inject_at) begin
        req_write = 1'b1; req_addr = 32'h108; req_siz = 2'b00; req_wdata = 32'hDEADBEEF;
        req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
    end
  endtask

  initial begin
    int cnt, cyc_n, a, r, t, pb, mism;
    logic [31:0] exp_rd;
    logic [7:0]  img [16];
    logic [47:0] v;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk({busy, done, bus_as, bus_ds} == 4'b0, "R1 during reset", {28'd0, busy, done, bus_as, bus_ds}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, bus_as, bus_ds} == 4'b0, "R1 after reset", {28'd0, busy, done, bus_as, bus_ds}, 32'd0);

    // vector table: R3 R4 R5 R6 R7
    for (int vi = 0; vi < 12; vi++) begin
      v = VEC[vi];
      run_xfer(v[47], 32'h100 | 32'(v[46:43]), int'(v[42:40]), v[31:0], v[39:38],
               int'(v[37:35]), 1'b0, -1, cnt);
      pb = (v[39:38] == 2'b01) ? 1 : (v[39:38] == 2'b10) ? 2 : 4;
      a = int'(v[46:43]); r = int'(v[42:40]); cyc_n = 0;
      while (r > 0) begin
        t = pb - (a % pb);
        if (t > r) t = r;
        a += t; r -= t; cyc_n++;
      end
      chk(acks == cyc_n, "R4 bus cycle count", 32'(acks), 32'(cyc_n));
      chk(exp_rem == 0, "R3 all bytes moved", 32'(exp_rem), 32'd0);
      chk(cnt == cyc_n * (int'(v[37:35]) + 3), "R7 done timing", 32'(cnt), 32'(cyc_n * (int'(v[37:35]) + 3)));
      chk(!bus_err, "R8 no error within limit", {31'd0, bus_err}, 32'd0);
      if (v[47]) begin
        for (int i = 0; i < 16; i++) img[i] = 8'hA0 + 8'(i);
        for (int j = 0; j < int'(v[42:40]); j++) img[4'(v[46:43] + 4'(j))] = ob[j];
        mism = 0;
        for (int i = 0; i < 16; i++) if (mem[i] != img[i]) mism++;
        chk(mism == 0, "R5 port memory after write", 32'(mism), 32'd0);
      end else begin
        exp_rd = '0;
        for (int j = 0; j < int'(v[42:40]); j++) exp_rd = {exp_rd[23:0], 8'hA0 + 8'(v[46:43] + 4'(j))};
        chk(rd_data == exp_rd, "R6 read assembly", rd_data, exp_rd);
      end
    end

    // R8 silent port: timeout
    run_xfer(1'b0, 32'h100, 4, 32'h0, 2'b11, 0, 1'b1, -1, cnt);
    chk(bus_err == 1'b1, "R8 silent port flags error", {31'd0, bus_err}, 32'd1);
    chk(cnt == TO_LIM + 3, "R8 timeout timing", 32'(cnt), 32'(TO_LIM + 3));
    chk(!bus_as && !bus_ds, "R8 strobes dropped", {30'd0, bus_as, bus_ds}, 32'd0);

    // R8 one wait cycle past the limit
    run_xfer(1'b0, 32'h100, 2, 32'h0, 2'b10, TO_LIM + 1, 1'b0, -1, cnt);
    chk(bus_err == 1'b1, "R8 ack one cycle late", {31'd0, bus_err}, 32'd1);
    chk(acks == 0, "R8 late ack not taken", 32'(acks), 32'd0);

    // recovery after an error, ack exactly at the limit
    run_xfer(1'b0, 32'h102, 2, 32'h0, 2'b11, TO_LIM, 1'b0, -1, cnt);
    chk(!bus_err && rd_data == 32'h0000A2A3, "R8 transfer after error", rd_data, 32'h0000A2A3);

    // R9 request while busy
    run_xfer(1'b1, 32'h100, 4, 32'h01020304, 2'b01, 0, 1'b0, 4, cnt);
    chk(acks == 4, "R9 cycles of first transfer only", 32'(acks), 32'd4);
    mism = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (bus_as || busy) mism++;
    end
    chk(mism == 0, "R9 no bus cycle after busy request", 32'(mism), 32'd0);
    chk(mem[8] == 8'hA8 && mem[11] == 8'hAB, "R9 ignored write left memory", {mem[8], mem[11]}, 32'hA8AB);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule